// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Sequencer

This block controls the drive-enable line of a switching amplifier power stage. It takes digitized comparator flags from the current sensing path: one that reports an overcurrent and one that reports that the current has dropped below a lower threshold. When the overcurrent flag is seen, drive permission is withdrawn at once, so every gate of the bridge discharges. The inductor current then decays through the body diodes. Drive is granted again according to one of two selectable rules.

In timer mode, drive returns once the overcurrent flag has stayed clear for a programmable number of clock cycles. The default is 200 cycles, which is 2 us at 100 MHz. A new overcurrent during that wait starts the count again. In dual-threshold mode, drive returns as soon as the low-current flag reports that the current is below the lower threshold and the overcurrent flag is clear. Under a persistent overload the loop therefore keeps tripping and re-arming, and behaves like a hysteretic current regulator instead of latching off.

Both flags pass through a two-stage synchronizer. After reset, drive stays disabled for a configurable start-up delay. Each trip emits a one-cycle pulse so that downstream logic can count limit events. For fail-safe wiring, the polarity of the enable output can be set to active low.

Top module: `cbc_limit_seq`

## Requirements
- R1: After reset is released, drive stays disabled for START_CYC cycles. Drive permission first appears in the output cycle that follows the START_CYC-th rising clock edge after release. Throughout reset, drive is disabled and trip_o is 0.
- R2: While drive is permitted, a high oc_i removes drive permission in the output cycle that follows the second rising edge after oc_i was raised. This delay comes from the two-stage synchronizer.
- R3: trip_o is high for exactly one cycle for each transition from permitted to disabled. That cycle is the same one in which permission drops. trip_o stays low during the hold-off and during start-up.
- R4: Timer mode is selected by mode_i = 0. Drive returns once the synchronized overcurrent flag has been seen low on HOLD_CYC consecutive rising edges. With a release of oc_i, this places the return in the output cycle after edge HOLD_CYC+2.
- R5: In timer mode, if the synchronized overcurrent flag is seen high during the hold-off, the count restarts from zero.
- R6: Dual-threshold mode is selected by mode_i = 1. Drive returns on the edge at which the synchronized low-current flag is high and the synchronized overcurrent flag is low. In this mode, elapsed hold-off time alone never re-enables drive.
- R7: In dual-threshold mode, a high lo_i has no effect while the synchronized overcurrent flag is still high.
- R8: With EN_ACTIVE_LOW = 1, drv_en_o is 0 while drive is permitted and 1 otherwise, including throughout reset. With EN_ACTIVE_LOW = 0, drv_en_o is 1 while drive is permitted.
- R9: While the overload persists, the block repeats trip and re-enable cycles. Each repeat produces its own trip pulse and the same hold-off timing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| oc_i | input | 1 | Overcurrent comparator flag, asynchronous |
| lo_i | input | 1 | Below-lower-threshold comparator flag, asynchronous |
| mode_i | input | 1 | Re-arm rule: 0 = timer, 1 = dual threshold |
| drv_en_o | output | 1 | Drive enable, polarity set by EN_ACTIVE_LOW |
| trip_o | output | 1 | One-cycle pulse on each trip |

## Verification
The overcurrent flag is driven as a long hold, as a release followed by a one-cycle reassertion inside the hold-off, and as a train of repeated overloads. These patterns separate a correct restart of the hold-off count from a count that merely pauses, and from an off-by-one at the release point. In dual-threshold mode, the bench first leaves the low-current flag idle for twice the hold-off length, which shows that the timer plays no part in that mode. It then raises the low-current flag while the overcurrent flag is still high, which shows that the two flags are combined and not tested one at a time. A second instance with inverted polarity runs on the same stimulus, so every cycle also checks the output encoding.

// File: rtl/cbc_pkg.sv
package cbc_pkg;
  typedef enum logic [1:0] {
    ST_BOOT = 2'd0,
    ST_RUN  = 2'd1,
    ST_HOLD = 2'd2
  } cbc_state_e;

  typedef enum logic {
    MODE_TIMER = 1'b0,
    MODE_DUAL  = 1'b1
  } cbc_mode_e;
endpackage

// File: rtl/cbc_sync.sv
module cbc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= d_i;
    end else begin : g_next
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) stg[g] <= '0;
        else         stg[g] <= stg[g-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/cbc_ctrl.sv
module cbc_ctrl
  import cbc_pkg::*;
#(
  parameter int HOLD_CYC  = 200,
  parameter int START_CYC = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_s_i,
  input  logic lo_s_i,
  input  logic mode_i,
  output logic permit_o,
  output logic trip_o
);
  localparam int MAX_CYC = (HOLD_CYC > START_CYC) ? HOLD_CYC : START_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST  = CNT_W'(HOLD_CYC - 1);
  localparam logic [CNT_W-1:0] START_LAST = CNT_W'(START_CYC - 1);

  cbc_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_BOOT: begin
        if (cnt_q == START_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      ST_RUN: begin
        if (oc_s_i) begin
          state_d = ST_HOLD;
          cnt_d   = '0;
        end
      end
      ST_HOLD: begin
        if (oc_s_i) begin
          cnt_d = '0;
        end else if (mode_i == MODE_DUAL) begin
          if (lo_s_i) state_d = ST_RUN;
        end else if (cnt_q == HOLD_LAST) begin
          state_d = ST_RUN;
          cnt_d   = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end
      default: begin
        state_d = ST_BOOT;
        cnt_d   = '0;
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_BOOT;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  // drop permission in the same cycle the synchronized flag appears
  assign permit_o = (state_q == ST_RUN) && !oc_s_i;
  assign trip_o   = (state_q == ST_RUN) &&  oc_s_i;
endmodule

// File: rtl/cbc_out.sv
module cbc_out #(
  parameter bit ACTIVE_LOW = 1'b0
) (
  input  logic permit_i,
  output logic en_o
);
  if (ACTIVE_LOW) begin : g_low
    assign en_o = ~permit_i;
  end else begin : g_high
    assign en_o = permit_i;
  end
endmodule

// File: rtl/cbc_limit_seq.sv
module cbc_limit_seq #(
  parameter int HOLD_CYC      = 200,
  parameter int START_CYC     = 100,
  parameter int SYNC_STAGES   = 2,
  parameter bit EN_ACTIVE_LOW = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic oc_i,
  input  logic lo_i,
  input  logic mode_i,
  output logic drv_en_o,
  output logic trip_o
);
  logic [1:0] flag_s;
  logic       permit;

  cbc_sync #(.W(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({lo_i, oc_i}),
    .q_o   (flag_s)
  );

  cbc_ctrl #(.HOLD_CYC(HOLD_CYC), .START_CYC(START_CYC)) ctrl_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .oc_s_i  (flag_s[0]),
    .lo_s_i  (flag_s[1]),
    .mode_i  (mode_i),
    .permit_o(permit),
    .trip_o  (trip_o)
  );

  cbc_out #(.ACTIVE_LOW(EN_ACTIVE_LOW)) out_i (
    .permit_i(permit),
    .en_o    (drv_en_o)
  );
endmodule

// File: rtl/cbc_limit_seq_chk.sv
module cbc_limit_seq_chk #(
  parameter int START_CYC     = 100,
  parameter bit EN_ACTIVE_LOW = 1'b0
) (
  input logic clk_i,
  input logic rst_ni,
  input logic oc_i,
  input logic drv_en_o,
  input logic trip_o
);
  logic permit;
  int   since_rst;

  assign permit = drv_en_o ^ EN_ACTIVE_LOW;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)                    since_rst <= 0;
    else if (since_rst < START_CYC) since_rst <= since_rst + 1;

  // R3
  trip_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |=> !trip_o);

  // R3
  trip_disables_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trip_o |-> !permit);

  // R2
  rearm_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(permit) |-> !$past(oc_i));

  // R1
  boot_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    permit |-> (since_rst >= START_CYC));
endmodule

bind cbc_limit_seq cbc_limit_seq_chk #(
  .START_CYC    (START_CYC),
  .EN_ACTIVE_LOW(EN_ACTIVE_LOW)
) chk_i (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .oc_i    (oc_i),
  .drv_en_o(drv_en_o),
  .trip_o  (trip_o)
);

// File: tb/cbc_limit_seq_tb_top.sv
module cbc_limit_seq_tb_top;
  localparam int HOLD  = 8;
  localparam int START = 6;

  typedef struct {
    bit    en;
    bit    trip;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic oc = 1'b0, lo = 1'b0, mode = 1'b0;
  logic en_h, trip_h, en_l, trip_l;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #4 clk = ~clk;

  cbc_limit_seq #(.HOLD_CYC(HOLD), .START_CYC(START), .EN_ACTIVE_LOW(1'b0)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .oc_i(oc), .lo_i(lo), .mode_i(mode),
    .drv_en_o(en_h), .trip_o(trip_h)
  );

  cbc_limit_seq #(.HOLD_CYC(HOLD), .START_CYC(START), .EN_ACTIVE_LOW(1'b1)) dut_lo_i (
    .clk_i(clk), .rst_ni(rst_ni), .oc_i(oc), .lo_i(lo), .mode_i(mode),
    .drv_en_o(en_l), .trip_o(trip_l)
  );

  task automatic check(input bit act, input bit exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  // monitor: compares one expected item per falling edge
  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      check(en_h,   e.en,   {e.tag, " drv_en"});
      check(trip_h, e.trip, {e.tag, " trip"});
      check(en_l,   ~e.en,  {e.tag, " R8 active-low drv_en"});
    end
  end

  // expectation after the next rising edge with the current inputs
  task automatic step(input bit en, input bit tr, input string tag);
    q.push_back('{en, tr, tag});
    @(negedge clk);
    #1;
  endtask

  task automatic trip_seq(input string tag);
    oc = 1'b1;
    step(1'b1, 1'b0, {tag, " R2 sync latency"});
    step(1'b0, 1'b1, {tag, " R3 trip pulse"});
    step(1'b0, 1'b0, {tag, " R3 pulse ends"});
  endtask

  task automatic timer_release(input string tag);
    oc = 1'b0;
    for (int i = 0; i < HOLD + 1; i++) step(1'b0, 1'b0, {tag, " R4 hold-off"});
    step(1'b1, 1'b0, {tag, " R4 re-enable"});
  endtask

  initial begin
    @(negedge clk);
    #1;
    step(1'b0, 1'b0, "R1 in reset");
    step(1'b0, 1'b0, "R1 in reset");
    rst_ni = 1'b1;
    for (int i = 0; i < START - 1; i++) step(1'b0, 1'b0, "R1 start-up");
    step(1'b1, 1'b0, "R1 start-up done");
    step(1'b1, 1'b0, "R1 running");

    // timer mode, long overload
    trip_seq("T1");
    for (int i = 0; i < 3; i++) step(1'b0, 1'b0, "R3 no pulse in hold");
    timer_release("T1");

    // timer restart on reassertion
    trip_seq("T2");
    oc = 1'b0;
    for (int i = 0; i < 4; i++) step(1'b0, 1'b0, "R5 counting");
    oc = 1'b1;
    step(1'b0, 1'b0, "R5 reassert");
    oc = 1'b0;
    step(1'b0, 1'b0, "R5 reassert");
    step(1'b0, 1'b0, "R5 restart");
    for (int i = 0; i < HOLD - 1; i++) step(1'b0, 1'b0, "R5 hold after restart");
    step(1'b1, 1'b0, "R5 re-enable");

    // persistent overload
    for (int k = 0; k < 3; k++) begin
      trip_seq("R9 repeat");
      timer_release("R9 repeat");
    end

    // dual-threshold mode
    mode = 1'b1;
    trip_seq("D1");
    oc = 1'b0;
    for (int i = 0; i < 2 * HOLD; i++) step(1'b0, 1'b0, "R6 timer ignored");
    lo = 1'b1;
    step(1'b0, 1'b0, "R6 lo sync");
    step(1'b0, 1'b0, "R6 lo sync");
    step(1'b1, 1'b0, "R6 re-enable");
    step(1'b1, 1'b0, "R6 running");

    // low flag while overcurrent still present
    trip_seq("D2");
    for (int i = 0; i < 5; i++) step(1'b0, 1'b0, "R7 lo with oc high");
    oc = 1'b0;
    step(1'b0, 1'b0, "R7 oc sync");
    step(1'b0, 1'b0, "R7 oc sync");
    step(1'b1, 1'b0, "R7 re-enable");
    lo = 1'b0;
    step(1'b1, 1'b0, "R7 running");

    @(negedge clk);
    #2;
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule